// File: doc/BRIEF.md
# Cache Range Maintenance Engine

This block carries out clean or invalidate maintenance over a contiguous run of cache lines. Software programs an operation with two register writes. It first writes the start address into the start register of the chosen operation kind. It then writes the end address into that kind's end register. Writing the end register is what launches the work. Each operation kind has its own start register, so a start value written for one kind is never used by the other.

Once launched, the engine visits every cache line whose base address is at or above the start address and at or below the end address. It presents one request per line on a simple request/acknowledge port that stands in for the cache tag and data arrays. The requester sees `busy` for the whole walk, and the walk cannot be interrupted. A pair whose end address is below its start, or whose two addresses fall in different pages, is rejected. A rejected pair raises a sticky error and touches no line.

Top module: `range_maint_engine`

## Requirements
- R1: After reset, `busy`, `done`, `req_valid`, `err_range` and `err_overrun` are all low.
- R2: `wr_sel` encoding: bit 1 selects the kind (0 clean, 1 invalidate) and bit 0 selects the register (0 start, 1 end). A start write on its own issues no request. An end write launches a walk that uses the start register of the same kind.
- R3: The walk covers every line base from the lowest multiple of `LINE_BYTES` (32) that is at or above start to the highest multiple that is at or below end. It goes in ascending order, and each line is issued exactly once.
- R4: At most one request is outstanding. `req_addr` and `req_op` stay stable while `req_valid` is high and `req_ack` is low. The next line is presented in the cycle after the acknowledge.
- R5: `req_op` is 0 for a clean walk and 1 for an invalidate walk.
- R6: `busy` rises in the cycle after a launching end write. In the cycle after the last line is acknowledged, `busy` is low and `done` is high, for one cycle only.
- R7: If end < start, or if the address bits above the page offset (4096-byte page, bits 12 and up) differ, the pair is rejected. A rejected pair sets the sticky `err_range`, which stays high until reset, and produces no request and no `done`.
- R8: An end write while `busy` is high is ignored: the running walk is unaffected and no later walk starts from it. It also sets the sticky `err_overrun`.
- R9: A valid pair that contains no line base, for example start 0x21 and end 0x3E, produces a `done` pulse in the cycle after the write, with no request and without raising `busy`.
- R10: A start write made while `busy` is high is stored for a later launch and does not alter the running walk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: bit 1 kind, bit 0 start/end |
| wr_data | input | ADDR_W | Address written |
| busy | output | 1 | Walk in progress; requester stalled |
| done | output | 1 | One-cycle completion pulse |
| err_range | output | 1 | Sticky rejected-range flag |
| err_overrun | output | 1 | Sticky end-write-while-busy flag |
| req_valid | output | 1 | Per-line request valid |
| req_op | output | 1 | 0 clean, 1 invalidate |
| req_addr | output | ADDR_W | Line-aligned address |
| req_ack | input | 1 | Per-line acknowledge |

## Verification
The hardest situation to reach from the ports is a register write that lands in the middle of a walk. A start write or an end write must arrive while a request is held unacknowledged, and it must leave the line sequence untouched. The bench gets there by launching a walk and keeping `req_ack` low on the first line. While the request waits, it writes a new start value and then an end value. It then acknowledges the remaining lines and checks that only the original range was walked. It also checks that the new start value is used by the next real launch. A sweep over start and end offsets within a page covers empty ranges, reversed ranges and page-edge rounding.

// File: rtl/rme_pkg.sv
package rme_pkg;
  // Kind of maintenance carried by each per-line request.
  typedef enum logic {
    OP_CLEAN = 1'b0,
    OP_INVAL = 1'b1
  } rme_op_e;

  // Register select: bit 1 chooses the kind, bit 0 chooses start/end.
  localparam int SEL_KIND_BIT = 1;
  localparam int SEL_END_BIT  = 0;
endpackage

// File: rtl/rme_start_regs.sv
module rme_start_regs #(
  parameter int ADDR_W = 32,
  parameter int N_KIND = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [1:0]                    wr_sel,
  input  logic [ADDR_W-1:0]             wr_data,
  output logic [N_KIND-1:0][ADDR_W-1:0] start_q
);
  import rme_pkg::*;

  // One start register per operation kind, written regardless of busy.
  for (genvar g = 0; g < N_KIND; g++) begin : g_kind
    logic             ld_en;
    logic [ADDR_W-1:0] start_d;

    always_comb begin
      ld_en   = wr_en && !wr_sel[SEL_END_BIT] && (int'(wr_sel[SEL_KIND_BIT]) == g);
      start_d = ld_en ? wr_data : start_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) start_q[g] <= '0;
      else        start_q[g] <= start_d;
    end
  end
endmodule

// File: rtl/rme_range_check.sv
module rme_range_check #(
  parameter int ADDR_W   = 32,
  parameter int LINE_LSB = 5,
  parameter int PAGE_LSB = 12
) (
  input  logic [ADDR_W-1:0] lo_addr,
  input  logic [ADDR_W-1:0] hi_addr,
  output logic              bad,
  output logic              empty,
  output logic [ADDR_W-1:0] first_line,
  output logic [ADDR_W-1:0] last_line
);
  localparam int LW = ADDR_W - LINE_LSB;

  logic [LW:0]     up_idx;
  logic [ADDR_W:0] first_ext;
  logic [ADDR_W:0] last_ext;

  always_comb begin
    // Lowest line base at or above the start address (one extra bit for carry).
    up_idx = {1'b0, lo_addr[ADDR_W-1:LINE_LSB]};
    if (|lo_addr[LINE_LSB-1:0]) up_idx = up_idx + {{LW{1'b0}}, 1'b1};
    first_ext  = {up_idx, {LINE_LSB{1'b0}}};
    last_ext   = {1'b0, hi_addr[ADDR_W-1:LINE_LSB], {LINE_LSB{1'b0}}};
    first_line = first_ext[ADDR_W-1:0];
    last_line  = last_ext[ADDR_W-1:0];
    bad   = (hi_addr < lo_addr) ||
            (hi_addr[ADDR_W-1:PAGE_LSB] != lo_addr[ADDR_W-1:PAGE_LSB]);
    empty = first_ext > last_ext;
  end
endmodule

// File: rtl/rme_walker.sv
module rme_walker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              launch_empty,
  input  logic              launch_op,
  input  logic [ADDR_W-1:0] launch_first,
  input  logic [ADDR_W-1:0] launch_last,
  input  logic              req_ack,
  output logic              busy,
  output logic              done,
  output logic              req_valid,
  output logic              req_op,
  output logic [ADDR_W-1:0] req_addr
);
  localparam int               LINE_LSB = $clog2(LINE_BYTES);
  localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(LINE_BYTES);

  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic              op_q, op_d;
  logic [ADDR_W-1:0] cur_q, cur_d;
  logic [ADDR_W-1:0] last_q, last_d;
  logic              ld_en, adv_en;

  // Next-state logic.
  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    ld_en  = !busy_q && launch;
    adv_en = busy_q && req_ack && (cur_q != last_q);
    if (busy_q && req_ack && (cur_q == last_q)) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end
    if (ld_en) busy_d = 1'b1;
    if (!busy_q && launch_empty) done_d = 1'b1;
    cur_d  = ld_en ? launch_first : (adv_en ? cur_q + STEP : cur_q);
    last_d = ld_en ? launch_last : last_q;
    op_d   = ld_en ? launch_op : op_q;
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      op_q   <= 1'b0;
      cur_q  <= '0;
      last_q <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      op_q   <= op_d;
      cur_q  <= cur_d;
      last_q <= last_d;
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign req_valid = busy_q;
  assign req_op    = op_q;
  assign req_addr  = cur_q;

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ack |=> req_valid && $stable(req_addr) && $stable(req_op));
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ack && (cur_q != last_q) |=> req_valid && (req_addr == $past(req_addr) + STEP));
  a_r3_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr[LINE_LSB-1:0] == '0));
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !req_valid);
endmodule

// File: rtl/range_maint_engine.sv
module range_maint_engine #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  output logic              busy,
  output logic              done,
  output logic              err_range,
  output logic              err_overrun,
  output logic              req_valid,
  output logic              req_op,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              req_ack
);
  import rme_pkg::*;

  localparam int LINE_LSB = $clog2(LINE_BYTES);
  localparam int PAGE_LSB = $clog2(PAGE_BYTES);
  localparam int N_KIND   = 2;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [N_KIND-1:0][ADDR_W-1:0] start_q;
  logic [ADDR_W-1:0] sel_start;
  logic              end_wr, accept, bad, empty;
  logic [ADDR_W-1:0] first_line, last_line;
  logic              launch, launch_empty;
  logic              err_range_q, err_range_d;
  logic              err_ovr_q, err_ovr_d;

  rme_start_regs #(.ADDR_W(ADDR_W), .N_KIND(N_KIND)) u_start (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .start_q (start_q)
  );

  assign sel_start = start_q[wr_sel[SEL_KIND_BIT]];

  rme_range_check #(.ADDR_W(ADDR_W), .LINE_LSB(LINE_LSB), .PAGE_LSB(PAGE_LSB)) u_chk (
    .lo_addr    (sel_start),
    .hi_addr    (wr_data),
    .bad        (bad),
    .empty      (empty),
    .first_line (first_line),
    .last_line  (last_line)
  );

  // Launch decode and sticky flags (next state).
  always_comb begin
    end_wr       = wr_en && wr_sel[SEL_END_BIT];
    accept       = end_wr && !busy;
    launch       = accept && !bad && !empty;
    launch_empty = accept && !bad && empty;
    err_range_d  = err_range_q | (accept && bad);
    err_ovr_d    = err_ovr_q | (end_wr && busy);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      err_range_q <= 1'b0;
      err_ovr_q   <= 1'b0;
    end else begin
      err_range_q <= err_range_d;
      err_ovr_q   <= err_ovr_d;
    end
  end

  rme_walker #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_walk (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .launch       (launch),
    .launch_empty (launch_empty),
    .launch_op    (wr_sel[SEL_KIND_BIT]),
    .launch_first (first_line),
    .launch_last  (last_line),
    .req_ack      (req_ack),
    .busy         (busy),
    .done         (done),
    .req_valid    (req_valid),
    .req_op       (req_op),
    .req_addr     (req_addr)
  );

  assign err_range   = err_range_q;
  assign err_overrun = err_ovr_q;

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_range |=> err_range);
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_overrun |=> err_overrun);
  a_r8_no_disturb: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en && wr_sel[SEL_END_BIT] && busy && !req_ack |=> busy && $stable(req_addr) && $stable(req_op));
  a_r7_no_launch: assert property (@(posedge clk) disable iff (!rst_sync_n)
    accept && bad |=> !busy && !done);
endmodule

// File: tb/range_maint_engine_bench.sv
module range_maint_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [1:0]    wr_sel;
  logic [AW-1:0] wr_data;
  logic          busy, done, err_range, err_overrun, req_valid, req_op;
  logic [AW-1:0] req_addr;
  logic          req_ack;

  int nvec = 0;
  int nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  range_maint_engine #(.ADDR_W(AW), .LINE_BYTES(32), .PAGE_BYTES(4096)) u_range_maint_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .busy(busy), .done(done), .err_range(err_range), .err_overrun(err_overrun),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_ack(req_ack)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0; req_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !req_valid && !err_range && !err_overrun, "R1",
        {busy, done, req_valid, err_range, err_overrun}, 0);
  endtask

  task automatic wr(input logic [1:0] sel, input int data);
    wr_en = 1'b1; wr_sel = sel; wr_data = AW'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Acknowledge n lines starting at first; checks order, op, hold and completion.
  task automatic walk(input int op, input int first, input int n, input int dly);
    chk(busy == 1'b1, "R6", busy, 1);
    for (int i = 0; i < n; i++) begin
      int exp;
      exp = first + i * 32;
      chk(req_valid && req_addr == AW'(exp), "R3", req_addr, exp);
      chk(req_op == op[0], "R5", req_op, op);
      for (int d = 0; d < (dly + i) % 3; d++) begin
        @(negedge clk);
        chk(req_valid && req_addr == AW'(exp), "R4", req_addr, exp);
      end
      req_ack = 1'b1;
      @(negedge clk);
      req_ack = 1'b0;
    end
    chk(done && !busy && !req_valid, "R6", {done, busy, req_valid}, 3'b100);
    @(negedge clk);
    chk(!done && !busy, "R6", {done, busy}, 0);
  endtask

  task automatic run_op(input int op, input int s, input int e, input int dly);
    bit bad;
    int first, last, n;
    wr({op[0], 1'b0}, s);
    wr({op[0], 1'b1}, e);
    bad   = (e < s) || ((s >> 12) != (e >> 12));
    first = ((s + 31) / 32) * 32;
    last  = (e / 32) * 32;
    n     = (first > last) ? 0 : (last - first) / 32 + 1;
    if (bad) begin
      chk(!busy && !done && !req_valid && err_range, "R7",
          {busy, done, req_valid, err_range}, 1);
      @(negedge clk);
      chk(!busy && !done && !req_valid, "R7", {busy, done, req_valid}, 0);
    end else if (n == 0) begin
      chk(done && !busy && !req_valid, "R9", {done, busy, req_valid}, 3'b100);
      @(negedge clk);
      chk(!done && !busy && !req_valid, "R9", {done, busy, req_valid}, 0);
    end else begin
      walk(op, first, n, dly);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    do_reset();

    // R2: a start write alone issues nothing
    wr(2'd0, 'h8000);
    repeat (2) begin
      chk(!req_valid && !busy && !done, "R2", {req_valid, busy, done}, 0);
      @(negedge clk);
    end
    // R2: each kind keeps its own start register
    wr(2'd2, 'h8100);
    wr(2'd3, 'h8120);
    walk(1, 'h8100, 2, 0);
    wr(2'd1, 'h8020);
    walk(0, 'h8000, 2, 1);

    // R9 zero-line ranges, R3 single line and full page
    run_op(0, 'h0021, 'h003E, 0);
    run_op(1, 'h2FF1, 'h2FFF, 0);
    run_op(0, 'h4020, 'h4020, 1);
    run_op(1, 'h5000, 'h5FFF, 2);
    chk(!err_range, "R7", err_range, 0);

    // R7: page crossing and reversed pairs, flag stays sticky
    run_op(0, 'h1FE0, 'h2000, 0);
    run_op(1, 'h3400, 'h3200, 0);
    run_op(0, 'h6000, 'h6040, 0);
    chk(err_range, "R7", err_range, 1);

    // Sweep of start/end offsets within one page for both kinds
    for (int op = 0; op < 2; op++)
      for (int so = 0; so < 4096; so += 713)
        for (int eo = 0; eo < 4096; eo += 659)
          run_op(op, 'h3000 + so, 'h3000 + eo, so + eo);

    // R8 and R10: writes during a held request
    do_reset();
    wr(2'd0, 'h6000);
    wr(2'd1, 'h60FF);
    chk(req_valid && req_addr == AW'('h6000), "R10", req_addr, 'h6000);
    wr(2'd0, 'h7000);
    chk(req_valid && req_addr == AW'('h6000), "R10", req_addr, 'h6000);
    wr(2'd1, 'h7040);
    chk(err_overrun, "R8", err_overrun, 1);
    chk(req_valid && req_addr == AW'('h6000), "R8", req_addr, 'h6000);
    walk(0, 'h6000, 8, 0);
    chk(!req_valid && !busy, "R8", {req_valid, busy}, 0);
    chk(err_overrun && !err_range, "R8", {err_overrun, err_range}, 2'b10);
    wr(2'd1, 'h7040);
    walk(0, 'h7000, 3, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule